// File: doc/BRIEF.md
# Convolution Row Delay-and-Add Combiner

A matrix-vector engine can compute, for one input element x of a feature-map row, its three products with the three column vectors of a 3×3 kernel in a single pass. This block takes those three partial products each cycle and rebuilds the convolution row from them. It holds each product in a short register chain until the products of the next two input elements arrive. It then adds the aligned terms, so that output O_t = x_t·k1 + x_(t+1)·k2 + x_(t+2)·k3. Once the chain is primed, one finished sum is produced for every accepted element. As a result, the engine needs only one output lane per convolution row.

Several feature-map channels run side by side in independent lanes that share one control path. The stride is chosen per row: a row-start marker on the first element clears the chain and captures the stride, and the combiner then keeps only every stride-th finished sum. An idle input valid freezes the chain, so the upstream engine may insert gaps freely.

Top module: `dcc_row_combiner`

## Requirements
- R1: For each lane l, the field in_pp[l*3*IN_W + j*IN_W +: IN_W] is a two's-complement term: j=0 is x·k1, j=1 is x·k2 and j=2 is x·k3. For element t of a row, the result in out_sum[l*OUT_W +: OUT_W] is term0(t) + term1(t+1) + term2(t+2).
- R2: The sum for O_t, with out_valid high, appears on the clock edge that accepts element t+2 of the row. It is held for one cycle. At stride 1, one result follows every accepted element from the third element on.
- R3: out_sum lanes are OUT_W = IN_W+2 bits signed and never overflow. With IN_W=4, the extreme results -24 and +21 are exact.
- R4: The stride is stride_cfg in 1..3, and the value 0 acts as 1. Only O_0, O_s, O_2s, ... are flagged valid; the other finished sums are dropped.
- R5: stride_cfg is captured only when an element is accepted with row_start high. Changes on other cycles have no effect on the current row.
- R6: An element is accepted when in_valid is high. If row_start is also high, it is element 0 of a new row. Terms never cross rows: a row start in the middle of a row discards the pending terms, and no result appears until element 2 of the new row.
- R7: A cycle with in_valid low is a stall. out_valid is low on the following cycle, out_sum holds its value, and the chain resumes with no term lost. row_start without in_valid does nothing.
- R8: Elements offered after reset but before the first row start are ignored and produce no result.
- R9: During and after reset, out_valid is 0 and out_sum is all zero.
- R10: Lanes are independent: each lane's result depends only on its own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Partial products on in_pp are valid this cycle |
| row_start | input | 1 | With in_valid: this element is the first of a row |
| stride_cfg | input | 2 | Stride for the row, captured at row start (0 acts as 1) |
| in_pp | input | LANES*3*IN_W | Three signed partial products per lane |
| out_valid | output | 1 | out_sum holds a kept convolution result |
| out_sum | output | LANES*OUT_W | One signed result per lane |

## Verification
The result O_t is due on the single clock edge that accepts element t+2, so its out_valid and sum are visible one register stage after that element is presented. The bench drives each element half a cycle before the edge. Its behavioural model, which keeps the row history of every lane, works out what must appear after that edge. The bench then compares out_valid and every lane 1 ns after the edge, on every cycle. Stall cycles are compared the same way: the expected value there is a low valid and an unchanged sum, which covers the hold and row-isolation rules as well as the arithmetic.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   localparam int TERMS    = 3;
   localparam int STRIDE_W = 2;

   // a zero stride code is treated as stride 1
   function automatic logic [STRIDE_W-1:0] norm_stride(input logic [STRIDE_W-1:0] s);
      return (s == '0) ? STRIDE_W'(1) : s;
   endfunction
endpackage

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
   import dcc_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                row_start,
   input  logic [STRIDE_W-1:0] stride_cfg,
   output logic                take,
   output logic                first,
   output logic                emit
);
   logic                active;
   logic                primed;
   logic [STRIDE_W-1:0] phase;
   logic [STRIDE_W-1:0] stride_q;
   logic                complete;

   assign first    = in_valid && row_start;
   assign take     = in_valid && (row_start || active);
   assign complete = take && !row_start && primed && active;
   assign emit     = complete && (phase == '0);

   // warm-up: element 0 sets active, element 1 sets primed, element 2 completes O_0
   logic seen_one;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         seen_one <= 1'b0;
         primed   <= 1'b0;
         phase    <= '0;
         stride_q <= STRIDE_W'(1);
      end else if (first) begin
         active   <= 1'b1;
         seen_one <= 1'b1;
         primed   <= 1'b0;
         phase    <= '0;
         stride_q <= norm_stride(stride_cfg);
      end else if (take) begin
         if (!primed) begin
            primed <= seen_one;
         end else begin
            phase <= (phase == stride_q - STRIDE_W'(1)) ? '0 : phase + STRIDE_W'(1);
         end
      end
   end
endmodule

// File: rtl/dcc_lane.sv
module dcc_lane #(
   parameter int IN_W  = 4,
   parameter int OUT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              first,
   input  logic              emit,
   input  logic [3*IN_W-1:0] pp,
   output logic [OUT_W-1:0]  sum
);
   localparam int EXT = OUT_W - IN_W;

   logic [OUT_W-1:0] t0, t1, t2;
   logic [OUT_W-1:0] s1, s2;

   assign t0 = {{EXT{pp[IN_W-1]}},   pp[IN_W-1:0]};
   assign t1 = {{EXT{pp[2*IN_W-1]}}, pp[2*IN_W-1:IN_W]};
   assign t2 = {{EXT{pp[3*IN_W-1]}}, pp[3*IN_W-1:2*IN_W]};

   // s1: k1 term of previous element; s2: k1+k2 terms of the two previous elements
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1  <= '0;
         s2  <= '0;
         sum <= '0;
      end else if (take) begin
         s1 <= t0;
         s2 <= first ? '0 : (s1 + t1);
         if (emit) sum <= s2 + t2;
      end
   end
endmodule

// File: rtl/dcc_row_combiner.sv
module dcc_row_combiner
   import dcc_pkg::*;
#(
   parameter  int LANES = 2,
   parameter  int IN_W  = 4,
   localparam int OUT_W = IN_W + $clog2(TERMS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   row_start,
   input  logic [STRIDE_W-1:0]    stride_cfg,
   input  logic [LANES*3*IN_W-1:0] in_pp,
   output logic                   out_valid,
   output logic [LANES*OUT_W-1:0] out_sum
);
   localparam int LANE_IN = TERMS * IN_W;

   if (LANES < 1 || LANES > 64) begin : g_bad_lanes
      $error("dcc_row_combiner: LANES must be 1..64");
   end
   if (IN_W < 2 || IN_W > 16) begin : g_bad_width
      $error("dcc_row_combiner: IN_W must be 2..16");
   end

   logic take, first, emit;

   dcc_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .row_start  (row_start),
      .stride_cfg (stride_cfg),
      .take       (take),
      .first      (first),
      .emit       (emit)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      dcc_lane #(.IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .take  (take),
         .first (first),
         .emit  (emit),
         .pp    (in_pp[l*LANE_IN +: LANE_IN]),
         .sum   (out_sum[l*OUT_W +: OUT_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= emit;
   end
endmodule

// File: rtl/dcc_row_combiner_chk.sv
module dcc_row_combiner_chk #(
   parameter  int LANES = 2,
   parameter  int IN_W  = 4,
   localparam int OUT_W = IN_W + 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   row_start,
   input logic [1:0]             stride_cfg,
   input logic [LANES*3*IN_W-1:0] in_pp,
   input logic                   out_valid,
   input logic [LANES*OUT_W-1:0] out_sum
);
   localparam int LO = -3 * (2 ** (IN_W - 1));
   localparam int HI = 3 * (2 ** (IN_W - 1) - 1);

   logic [1:0] row_cnt;
   logic [2:0] gap;
   logic       had_out;
   logic [1:0] stride_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_cnt  <= '0;
         gap      <= '0;
         had_out  <= 1'b0;
         stride_c <= 2'd1;
      end else if (in_valid && row_start) begin
         row_cnt  <= 2'd1;
         gap      <= 3'd1;
         had_out  <= 1'b0;
         stride_c <= (stride_cfg == 2'd0) ? 2'd1 : stride_cfg;
      end else begin
         if (in_valid && row_cnt != 2'd0 && row_cnt != 2'd3) row_cnt <= row_cnt + 2'd1;
         if (out_valid) begin
            had_out <= 1'b1;
            gap     <= {2'b00, in_valid};
         end else if (in_valid && gap != 3'd7) begin
            gap <= gap + 3'd1;
         end
      end
   end

   // R6: no result before element 2 of the current row
   p_first_after_three_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> row_cnt == 2'd3);

   // R4: successive results in a row are stride accepted elements apart
   p_stride_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && had_out) |-> gap == {1'b0, stride_c});

   // R7: a stall cycle yields no result and a frozen sum
   p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> !out_valid);

   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(out_sum));

   for (genvar l = 0; l < LANES; l++) begin : g_rng
      // R3: every lane result lies in the range of three signed terms
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> ($signed(out_sum[l*OUT_W +: OUT_W]) >= LO &&
                        $signed(out_sum[l*OUT_W +: OUT_W]) <= HI));
   end
endmodule

bind dcc_row_combiner dcc_row_combiner_chk #(.LANES(LANES), .IN_W(IN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .row_start  (row_start),
   .stride_cfg (stride_cfg),
   .in_pp      (in_pp),
   .out_valid  (out_valid),
   .out_sum    (out_sum)
);

// File: tb/sim_dcc_row_combiner.sv
`timescale 1ns/1ps
module sim_dcc_row_combiner;
   localparam int LANES = 2;
   localparam int IN_W  = 4;
   localparam int OUT_W = IN_W + 2;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic                    row_start = 1'b0;
   logic [1:0]              stride_cfg = 2'd1;
   logic [LANES*3*IN_W-1:0] in_pp = '0;
   logic                    out_valid;
   logic [LANES*OUT_W-1:0]  out_sum;

   always #5 clk = ~clk;

   dcc_row_combiner #(.LANES(LANES), .IN_W(IN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .row_start(row_start),
      .stride_cfg(stride_cfg), .in_pp(in_pp), .out_valid(out_valid), .out_sum(out_sum)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 0;
   string cur_req  = "R9";

   // behavioural model
   int hist [LANES][3][64];
   bit m_active = 0;
   int m_idx = 0;
   int m_s = 1;
   bit exp_v = 0;
   int exp_sum [LANES];
   int drv [LANES][3];
   int lfsr = 32'h1234_5678;

   task automatic chk(bit ok, string what, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, expv);
      end
   endtask

   task automatic gen_pp();
      for (int l = 0; l < LANES; l++)
         for (int j = 0; j < 3; j++) begin
            lfsr = lfsr * 1103515245 + 12345;
            drv[l][j] = ((lfsr >>> 16) & 15) - 8;
         end
   endtask

   task automatic fill_pp(int v);
      for (int l = 0; l < LANES; l++)
         for (int j = 0; j < 3; j++) drv[l][j] = v;
   endtask

   task automatic compare();
      chk(out_valid == exp_v, "out_valid", int'(out_valid), int'(exp_v));
      for (int l = 0; l < LANES; l++) begin
         int a;
         a = $signed(out_sum[l*OUT_W +: OUT_W]);
         chk(a == exp_sum[l], $sformatf("lane%0d sum", l), a, exp_sum[l]);
      end
   endtask

   task automatic step(bit rs, bit v, int scfg);
      @(negedge clk);
      row_start  = rs;
      in_valid   = v;
      stride_cfg = 2'(scfg);
      for (int l = 0; l < LANES; l++)
         for (int j = 0; j < 3; j++)
            in_pp[(l*3+j)*IN_W +: IN_W] = IN_W'(drv[l][j]);
      exp_v = 0;
      if (v && (rs || m_active)) begin
         if (rs) begin
            m_active = 1;
            m_idx = 0;
            m_s = (scfg == 0) ? 1 : scfg;
         end else begin
            m_idx++;
         end
         for (int l = 0; l < LANES; l++)
            for (int j = 0; j < 3; j++) hist[l][j][m_idx % 64] = drv[l][j];
         if (m_idx >= 2 && ((m_idx - 2) % m_s) == 0) begin
            exp_v = 1;
            for (int l = 0; l < LANES; l++)
               exp_sum[l] = hist[l][0][(m_idx-2) % 64] + hist[l][1][(m_idx-1) % 64]
                          + hist[l][2][m_idx % 64];
         end
      end
      @(posedge clk);
      #1;
      compare();
   endtask

   // row of len elements; stall every stall_every elements; mid_s driven on later beats
   task automatic run_row(int len, int s, int mid_s, int stall_every);
      for (int k = 0; k < len; k++) begin
         gen_pp();
         if (stall_every > 0 && k > 0 && (k % stall_every) == 0) begin
            step(1'b0, 1'b0, mid_s);
            step(1'b1, 1'b0, mid_s);   // row_start without valid: no effect (R7)
         end
         step(k == 0, 1'b1, (k == 0) ? s : mid_s);
      end
   endtask

   initial begin
      for (int l = 0; l < LANES; l++) exp_sum[l] = 0;
      fill_pp(0);
      repeat (3) @(posedge clk);
      #1;
      cur_req = "R9";
      compare();
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      compare();

      cur_req = "R8";
      for (int k = 0; k < 5; k++) begin gen_pp(); step(1'b0, 1'b1, 1); end

      cur_req = "R1";
      run_row(12, 1, 1, 0);
      cur_req = "R2";
      run_row(3, 1, 1, 0);
      step(1'b0, 1'b0, 1);

      cur_req = "R3";
      for (int k = 0; k < 5; k++) begin fill_pp(-8); step(k == 0, 1'b1, 1); end
      for (int k = 0; k < 5; k++) begin fill_pp(7);  step(k == 0, 1'b1, 1); end
      chk(exp_sum[0] == 21, "model max", exp_sum[0], 21);

      cur_req = "R4";
      run_row(13, 2, 2, 0);
      run_row(14, 3, 3, 0);
      run_row(7, 0, 0, 0);

      cur_req = "R5";
      run_row(12, 1, 3, 0);
      run_row(12, 3, 1, 0);
      run_row(12, 2, 0, 0);

      cur_req = "R6";
      run_row(5, 1, 1, 0);
      run_row(1, 2, 2, 0);
      run_row(2, 1, 1, 0);
      run_row(9, 1, 1, 0);

      cur_req = "R7";
      run_row(15, 1, 1, 3);
      run_row(15, 2, 2, 2);

      cur_req = "R10";
      for (int k = 0; k < 6; k++) begin
         gen_pp();
         for (int j = 0; j < 3; j++) drv[1][j] = (k % 2 == 0) ? 7 : -8;
         step(k == 0, 1'b1, 1);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule